// File: doc/BRIEF.md
# Pseudorandom Per-Cylinder Knock Burst Generator

This block synthesises a signed sample stream that imitates the signal of an engine knock sensor. An external angle source pulses an event strobe at each cylinder's firing opportunity and gives that cylinder's index. On each strobe a hardware pseudorandom generator advances one step. Its upper bits are compared with that cylinder's programmed knock likelihood. If the result is "knock", the block plays an oscillation burst. The burst amplitude is set per cylinder and falls linearly to zero over a programmable power-of-two number of clock cycles. When there is no knock the output stays at zero.

The oscillation comes from a phase accumulator that addresses a 64-point sine table, which is computed from a 17-point quarter wave. A mode bit chooses the phase step. It is either a fixed constant or the engine speed multiplied by a gain, so the knock tone can follow engine speed. The sample output is meant for a DAC interface. A strobe that arrives during a burst cuts the burst off at once and starts a new decision.

The controller is a three-state machine:
- IDLE waits for a strobe. On a strobe it goes IDLE→DECIDE.
- DECIDE makes the knock decision. On knock it goes DECIDE→BURST. On no knock it goes DECIDE→IDLE. On a new strobe it goes DECIDE→DECIDE.
- BURST plays the wave. When the final cycle of the burst completes it goes BURST→IDLE. On a new strobe it goes BURST→DECIDE.

Top module: `knock_burst_gen`

## Requirements
- R1: After reset `active_o` is 0, `sample_o` is 0, and the pseudorandom state holds the seed parameter (default 32'h1D2C3B4A).
- R2: The pseudorandom state is a 32-bit right-shifting Galois register with feedback mask 32'h80200003. When the bit shifted out is 1, the mask is XORed in. The register steps exactly once for every cycle in which `evt_i` is high, and at no other time.
- R3: The knock decision uses the register value after the step: knock happens if and only if bits [31:25], read as an unsigned number 0..127, are less than the selected cylinder's 8-bit likelihood field. The field is `cfg_prob_i[8*c +: 8]` for cylinder c. A field of 0 never knocks and a field of 128 or more always knocks.
- R4: A strobe sampled at clock edge k leads to DECIDE at edge k, and, on knock, BURST at edge k+1. `active_o` is then high for exactly 2^`cfg_len_log2_i` consecutive cycles. The exponent is captured when the burst starts.
- R5: Within a burst the envelope is (amp × rem) >> L, where rem counts down from 2^L to 1, and |`sample_o`| never exceeds 128 × amp.
- R6: Each cylinder's amplitude is `cfg_amp_i[8*c +: 8]`. An amplitude of 0 gives an all-zero burst. A larger amplitude gives a larger peak, at least 32 × amp with a fixed phase step of 16'h0400 and L = 5.
- R7: With `cfg_mode_i` = 0 the phase step is `cfg_fixed_inc_i` and speed has no effect. With `cfg_mode_i` = 1 the phase step is (`speed_i` × `cfg_gain_i`) >> 8 and the fixed step has no effect.
- R8: `sample_o` is registered and is 0 in every cycle that follows a cycle outside BURST.
- R9: A strobe during a burst ends it. `active_o` is low from the next edge onward unless the new decision knocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| evt_i | input | 1 | Cylinder firing-opportunity strobe |
| evt_cyl_i | input | CYL_W | Cylinder index for the strobe |
| speed_i | input | SPEED_W | Engine speed |
| cfg_prob_i | input | NCYL*8 | Per-cylinder knock likelihood, 0..128 |
| cfg_amp_i | input | NCYL*8 | Per-cylinder burst amplitude |
| cfg_mode_i | input | 1 | Phase-step source: 0 fixed, 1 speed-scaled |
| cfg_fixed_inc_i | input | PHASE_W | Fixed phase step |
| cfg_gain_i | input | GAIN_W | Speed-to-step gain |
| cfg_len_log2_i | input | LEN_W | Burst length exponent |
| active_o | output | 1 | High while in BURST |
| sample_o | output | 16 | Signed output sample |

## Verification
The hardest outcome to bring about from the ports is a knock at an intermediate likelihood. Whether it happens depends on the hidden register state after every earlier strobe, including strobes that were cut off or never burst. The bench keeps its own model of the register, derived from the stated mask and seed, and steps it on every strobe it sends. It can then predict each decision of the vector table exactly. Restart is reached by sending a second strobe a few cycles into a running burst. The speed-mode cases set the unused step source to zero or non-zero, so that a leak from the wrong source shows up in the peak.

// File: rtl/knk_pkg.sv
package knk_pkg;
    localparam int SAMPLE_W = 16;
    localparam int PROB_W   = 8;
    localparam int AMP_W    = 8;
    localparam int LFSR_W   = 32;
    localparam int TAB_IDX_W = 6;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECIDE = 2'd1,
        ST_BURST  = 2'd2
    } knk_state_e;

    // quarter-wave magnitude, 0..16 covers 0..90 degrees
    function automatic logic [SAMPLE_W-2:0] quarter_mag(input logic [4:0] k);
        logic [SAMPLE_W-2:0] v;
        unique case (k)
            5'd0:  v = 15'd0;
            5'd1:  v = 15'd3212;
            5'd2:  v = 15'd6393;
            5'd3:  v = 15'd9512;
            5'd4:  v = 15'd12539;
            5'd5:  v = 15'd15446;
            5'd6:  v = 15'd18204;
            5'd7:  v = 15'd20787;
            5'd8:  v = 15'd23170;
            5'd9:  v = 15'd25329;
            5'd10: v = 15'd27245;
            5'd11: v = 15'd28898;
            5'd12: v = 15'd30273;
            5'd13: v = 15'd31356;
            5'd14: v = 15'd32137;
            5'd15: v = 15'd32609;
            5'd16: v = 15'd32767;
            default: v = 15'd0;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/knk_lfsr.sv
module knk_lfsr
    import knk_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 32'h1D2C3B4A,
    parameter logic [LFSR_W-1:0] MASK = 32'h80200003
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              step_i,
    output logic [LFSR_W-1:0] state_o
);
    logic [LFSR_W-1:0] state_q;
    logic [LFSR_W-1:0] state_next;

    always_comb begin
        state_next = state_q >> 1;
        if (state_q[0]) begin
            state_next = state_next ^ MASK;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= SEED;
        end else if (step_i) begin
            state_q <= state_next;
        end
    end

    assign state_o = state_q;

    // R2
    lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q != '0);

    // R2
    lfsr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !step_i |=> $stable(state_q));
endmodule

// File: rtl/knk_sine_rom.sv
module knk_sine_rom
    import knk_pkg::*;
(
    input  logic [TAB_IDX_W-1:0]       idx_i,
    output logic signed [SAMPLE_W-1:0] wave_o
);
    logic [1:0]          quad;
    logic [3:0]          sub;
    logic [4:0]          k;
    logic [SAMPLE_W-2:0] mag;

    assign quad = idx_i[5:4];
    assign sub  = idx_i[3:0];

    always_comb begin
        if (quad[0]) begin
            k = 5'd16 - {1'b0, sub};
        end else begin
            k = {1'b0, sub};
        end
        mag = quarter_mag(k);
        if (quad[1]) begin
            wave_o = -$signed({1'b0, mag});
        end else begin
            wave_o = $signed({1'b0, mag});
        end
    end
endmodule

// File: rtl/knk_envelope.sv
module knk_envelope
    import knk_pkg::*;
#(
    parameter int LEN_W = 4,
    localparam int REM_W = (1 << LEN_W),
    localparam int PROD_W = AMP_W + REM_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [LEN_W-1:0] len_log2_i,
    input  logic [AMP_W-1:0] amp_i,
    output logic [AMP_W-1:0] env_o,
    output logic             last_o
);
    logic [REM_W-1:0]  rem_q;
    logic [LEN_W-1:0]  len_q;
    logic [AMP_W-1:0]  amp_q;
    logic [PROD_W-1:0] prod;
    logic [REM_W:0]    rem_cap;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rem_q <= '0;
            len_q <= '0;
            amp_q <= '0;
        end else if (load_i) begin
            rem_q <= REM_W'(1) << len_log2_i;
            len_q <= len_log2_i;
            amp_q <= amp_i;
        end else if (step_i && rem_q != '0) begin
            rem_q <= rem_q - REM_W'(1);
        end
    end

    assign prod   = PROD_W'(amp_q) * PROD_W'(rem_q);
    assign env_o  = AMP_W'(prod >> len_q);
    assign last_o = (rem_q == REM_W'(1));

    assign rem_cap = (REM_W+1)'(1) << len_q;

    // R5
    rem_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        {1'b0, rem_q} <= rem_cap);

    // R5
    env_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        env_o <= amp_q);
endmodule

// File: rtl/knock_burst_gen.sv
module knock_burst_gen
    import knk_pkg::*;
#(
    parameter int NCYL    = 4,
    parameter int PHASE_W = 16,
    parameter int LEN_W   = 4,
    parameter int SPEED_W = 16,
    parameter int GAIN_W  = 8,
    parameter int GAIN_SH = 8,
    parameter logic [31:0] LFSR_SEED = 32'h1D2C3B4A,
    localparam int CYL_W  = (NCYL > 1) ? $clog2(NCYL) : 1,
    localparam int SPROD_W = SPEED_W + GAIN_W,
    localparam int EXT_W  = SPROD_W + PHASE_W,
    localparam int MULT_W = SAMPLE_W + AMP_W + 1
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     evt_i,
    input  logic [CYL_W-1:0]         evt_cyl_i,
    input  logic [SPEED_W-1:0]       speed_i,
    input  logic [NCYL*PROB_W-1:0]   cfg_prob_i,
    input  logic [NCYL*AMP_W-1:0]    cfg_amp_i,
    input  logic                     cfg_mode_i,
    input  logic [PHASE_W-1:0]       cfg_fixed_inc_i,
    input  logic [GAIN_W-1:0]        cfg_gain_i,
    input  logic [LEN_W-1:0]         cfg_len_log2_i,
    output logic                     active_o,
    output logic [SAMPLE_W-1:0]      sample_o
);
    knk_state_e state_q, state_next;

    logic [CYL_W-1:0]        cyl_q;
    logic [LFSR_W-1:0]       lfsr_state;
    logic [PROB_W-1:0]       prob_sel;
    logic [AMP_W-1:0]        amp_sel;
    logic [AMP_W-1:0]        amp_q;
    logic                    knock;
    logic                    env_load;
    logic                    env_step;
    logic [AMP_W-1:0]        env;
    logic                    env_last;
    logic [PHASE_W-1:0]      phase_q;
    logic [PHASE_W-1:0]      inc;
    logic [EXT_W-1:0]        speed_ext;
    logic signed [SAMPLE_W-1:0] wave;
    logic signed [MULT_W-1:0]   mult;
    logic [SAMPLE_W-1:0]     sample_q;

    // ---------------- random source ----------------
    knk_lfsr #(
        .SEED (LFSR_SEED),
        .MASK (32'h80200003)
    ) lfsr_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .step_i  (evt_i),
        .state_o (lfsr_state)
    );

    // ---------------- per-cylinder selection ----------------
    assign prob_sel = cfg_prob_i[cyl_q*PROB_W +: PROB_W];
    assign amp_sel  = cfg_amp_i[cyl_q*AMP_W +: AMP_W];
    assign knock    = ({1'b0, lfsr_state[LFSR_W-1 -: 7]} < prob_sel);

    // ---------------- state register ----------------
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            cyl_q   <= '0;
        end else begin
            state_q <= state_next;
            if (evt_i) begin
                cyl_q <= evt_cyl_i;
            end
        end
    end

    always_comb begin
        state_next = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (evt_i) state_next = ST_DECIDE;
            end
            ST_DECIDE: begin
                if (evt_i)      state_next = ST_DECIDE;
                else if (knock) state_next = ST_BURST;
                else            state_next = ST_IDLE;
            end
            ST_BURST: begin
                if (evt_i)         state_next = ST_DECIDE;
                else if (env_last) state_next = ST_IDLE;
                else               state_next = ST_BURST;
            end
            default: state_next = ST_IDLE;
        endcase
    end

    // ---------------- envelope ----------------
    assign env_load = (state_q == ST_DECIDE) && !evt_i && knock;
    assign env_step = (state_q == ST_BURST);

    knk_envelope #(
        .LEN_W (LEN_W)
    ) env_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (env_load),
        .step_i     (env_step),
        .len_log2_i (cfg_len_log2_i),
        .amp_i      (amp_sel),
        .env_o      (env),
        .last_o     (env_last)
    );

    // ---------------- phase step and accumulator ----------------
    assign speed_ext = EXT_W'(speed_i) * EXT_W'(cfg_gain_i);

    generate
        if (GAIN_SH + PHASE_W <= EXT_W) begin : g_inc
            always_comb begin
                if (cfg_mode_i) inc = speed_ext[GAIN_SH +: PHASE_W];
                else            inc = cfg_fixed_inc_i;
            end
        end else begin : g_inc_narrow
            always_comb begin
                if (cfg_mode_i) inc = PHASE_W'(speed_ext >> GAIN_SH);
                else            inc = cfg_fixed_inc_i;
            end
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            phase_q <= '0;
            amp_q   <= '0;
        end else if (env_load) begin
            phase_q <= '0;
            amp_q   <= amp_sel;
        end else if (state_q == ST_BURST) begin
            phase_q <= phase_q + inc;
        end
    end

    knk_sine_rom rom_i (
        .idx_i  (phase_q[PHASE_W-1 -: TAB_IDX_W]),
        .wave_o (wave)
    );

    assign mult = MULT_W'(wave) * $signed({{(MULT_W-AMP_W){1'b0}}, env});

    // ---------------- output process ----------------
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sample_q <= '0;
        end else if (state_q == ST_BURST) begin
            sample_q <= mult[AMP_W +: SAMPLE_W];
        end else begin
            sample_q <= '0;
        end
    end

    assign active_o = (state_q == ST_BURST);
    assign sample_o = sample_q;

    // ---------------- assertions ----------------
    logic [SAMPLE_W:0]   sample_mag;
    logic [AMP_W+7:0]    mag_bound;
    assign sample_mag = sample_q[SAMPLE_W-1] ? ((SAMPLE_W+1)'(0) - {sample_q[SAMPLE_W-1], sample_q})
                                             : {1'b0, sample_q};
    assign mag_bound  = {amp_q, 7'b0};

    // R4
    evt_to_decide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_i |=> (state_q == ST_DECIDE));

    // R3
    zero_prob_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_DECIDE && prob_sel == '0 && !evt_i) |=> (state_q == ST_IDLE));

    // R4
    burst_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_BURST && env_last && !evt_i) |=> (state_q == ST_IDLE));

    // R8
    quiet_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_BURST) |=> (sample_q == '0));

    // R5
    sample_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        {{(AMP_W+8-SAMPLE_W-1 > 0 ? AMP_W+8-SAMPLE_W-1 : 0){1'b0}}, sample_mag} <= {1'b0, mag_bound});

    // R9
    restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_BURST && evt_i) |=> !active_o);
endmodule

// File: tb/knock_burst_gen_tb.sv
module knock_burst_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        evt;
    logic [1:0]  evt_cyl;
    logic [15:0] speed;
    logic [31:0] prob;
    logic [31:0] amp;
    logic        mode;
    logic [15:0] fixed_inc;
    logic [7:0]  gain;
    logic [3:0]  len_log2;
    logic        active;
    logic [15:0] sample;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [31:0] model;

    always #2 clk = ~clk;

    knock_burst_gen dut_i (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .evt_i           (evt),
        .evt_cyl_i       (evt_cyl),
        .speed_i         (speed),
        .cfg_prob_i      (prob),
        .cfg_amp_i       (amp),
        .cfg_mode_i      (mode),
        .cfg_fixed_inc_i (fixed_inc),
        .cfg_gain_i      (gain),
        .cfg_len_log2_i  (len_log2),
        .active_o        (active),
        .sample_o        (sample)
    );

    task automatic check(input string req, input int act, input int exp, input bit ok);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lfsr_next(input logic [31:0] s);
        logic [31:0] n;
        n = s >> 1;
        if (s[0]) n = n ^ 32'h80200003;
        return n;
    endfunction

    // send one strobe; returns model knock decision
    task automatic fire(input logic [1:0] c, output bit knock);
        @(negedge clk);
        evt = 1'b1;
        evt_cyl = c;
        @(negedge clk);
        evt = 1'b0;
        model = lfsr_next(model);
        knock = ({1'b0, model[31:25]} < prob[c*8 +: 8]);
    endtask

    task automatic observe(input int cycles, output int act_cnt, output int peak);
        act_cnt = 0;
        peak = 0;
        for (int i = 0; i < cycles; i++) begin
            int m;
            @(negedge clk);
            if (active) act_cnt++;
            m = $signed(sample);
            if (m < 0) m = -m;
            if (m > peak) peak = m;
        end
    endtask

    // vector table: {cyl, prob, amp}
    localparam int NVEC = 10;
    localparam logic [17:0] VEC [NVEC] = '{
        {2'd0, 8'd128, 8'd200},
        {2'd1, 8'd0,   8'd100},
        {2'd2, 8'd64,  8'd150},
        {2'd3, 8'd100, 8'd255},
        {2'd2, 8'd20,  8'd80},
        {2'd1, 8'd128, 8'd60},
        {2'd0, 8'd64,  8'd120},
        {2'd3, 8'd0,   8'd255},
        {2'd1, 8'd110, 8'd90},
        {2'd0, 8'd40,  8'd170}
    };

    initial begin
        #800000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit k;
        int cnt, pk, pk_small, pk_big;
        rst_n = 1'b0; evt = 1'b0; evt_cyl = '0; speed = '0;
        prob = '0; amp = '0; mode = 1'b0; fixed_inc = 16'h0400;
        gain = '0; len_log2 = 4'd5;
        model = 32'h1D2C3B4A;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 active", active, 0, active == 1'b0);
        check("R1 sample", sample, 0, sample == 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after release", active, 0, active == 1'b0);

        // table walk: R2 R3 R4 R5 R6
        for (int v = 0; v < NVEC; v++) begin
            logic [1:0] c;
            c = VEC[v][17:16];
            prob[c*8 +: 8] = VEC[v][15:8];
            amp[c*8 +: 8]  = VEC[v][7:0];
            fire(c, k);
            observe(40, cnt, pk);
            check("R3 knock decision", cnt, k ? 32 : 0, cnt == (k ? 32 : 0));
            if (k) begin
                check("R5 peak upper", pk, VEC[v][7:0] * 128, pk <= VEC[v][7:0] * 128);
                check("R6 peak lower", pk, VEC[v][7:0] * 32, pk >= VEC[v][7:0] * 32);
            end else begin
                check("R8 silent no knock", pk, 0, pk == 0);
            end
        end

        // R4 short burst
        prob = {4{8'd128}};
        amp  = {4{8'd100}};
        len_log2 = 4'd2;
        fire(2'd1, k);
        observe(10, cnt, pk);
        check("R4 length 4", cnt, 4, cnt == 4);
        len_log2 = 4'd5;

        // R6 zero amplitude
        amp[8*2 +: 8] = 8'd0;
        fire(2'd2, k);
        observe(40, cnt, pk);
        check("R6 zero amp active", cnt, 32, cnt == 32);
        check("R6 zero amp silent", pk, 0, pk == 0);

        // R6 ordering
        amp[8*0 +: 8] = 8'd40;
        amp[8*3 +: 8] = 8'd220;
        fire(2'd0, k);
        observe(40, cnt, pk_small);
        fire(2'd3, k);
        observe(40, cnt, pk_big);
        check("R6 amp ordering", pk_big, pk_small, pk_big > pk_small);

        // R7 fixed mode ignores speed
        amp = {4{8'd200}};
        mode = 1'b0; fixed_inc = 16'h0000; speed = 16'h1000; gain = 8'd64;
        fire(2'd1, k);
        observe(40, cnt, pk);
        check("R7 fixed mode speed ignored", pk, 0, pk == 0);
        // R7 speed mode uses speed*gain
        mode = 1'b1;
        fire(2'd1, k);
        observe(40, cnt, pk);
        check("R7 speed mode tone", pk, 6400, pk >= 200 * 32);
        // R7 speed mode ignores fixed step
        fixed_inc = 16'h0400; speed = 16'h0000;
        fire(2'd1, k);
        observe(40, cnt, pk);
        check("R7 speed mode fixed ignored", pk, 0, pk == 0);
        mode = 1'b0;

        // R9 restart during burst into a no-knock cylinder
        prob[8*3 +: 8] = 8'd0;
        fire(2'd0, k);
        observe(5, cnt, pk);
        check("R9 burst running", active, 1, active == 1'b1);
        fire(2'd3, k);
        observe(40, cnt, pk);
        check("R9 burst cut", cnt, 0, cnt == 0);
        check("R8 silent after cut", pk, 0, pk == 0);

        // R2 decision still tracks model after restarts
        prob[8*1 +: 8] = 8'd64;
        fire(2'd1, k);
        observe(40, cnt, pk);
        check("R2 model after restart", cnt, k ? 32 : 0, cnt == (k ? 32 : 0));

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule